// File: doc/BRIEF.md
# Byte-Wide Multicycle RISC Core

This block is a small processor core with sixteen 8-bit general registers and an 8-bit instruction pointer. It reads each 16-bit instruction as two bytes over a byte-wide memory port, with the higher-order byte at the lower address. It then performs one of six operations: do nothing, stop, load a register from the address held in another register, store a register to the address held in another register, load an 8-bit constant, or add two registers. Address decoding, memory and output devices sit outside the core on the shared byte port.

The memory port is synchronous. The core raises a read strobe together with an address, and the byte is expected on the read-data input one cycle later. A write is a single-cycle strobe that carries both address and data. Every instruction runs through a fixed sequence of states: fetch the first byte, fetch the second byte, execute, and one extra memory cycle for loads and stores. A stop instruction leaves the core quiet, with the halted output raised, until the next reset.

Top module: `byte_risc_core`

## Requirements
- R1: During reset and in the first cycle after it, the core reads address 0xC0 with halted low, and every register reads as zero.
- R2: A fetch reads the instruction pointer and then the instruction pointer plus one in consecutive cycles. The first byte supplies bits 15:8, whose top four bits 15:12 are the opcode.
- R3: Opcode 0100 writes bits 7:0 of the instruction into the register indexed by bits 11:8.
- R4: Opcode 0101 writes the sum modulo 256 of the registers indexed by bits 7:4 and 3:0 into the register indexed by bits 11:8.
- R5: Opcode 0010 raises the read strobe at the address held in the register indexed by bits 7:4. It writes the byte returned one cycle later into the register indexed by bits 11:8.
- R6: Opcode 0011 raises the write strobe for exactly one cycle. The address is the register indexed by bits 11:8 and the data is the register indexed by bits 7:4. Read and write strobes are never high together.
- R7: Opcode 0000 and the unused opcodes 0110 to 1111 change no register and write no memory, whatever their low twelve bits hold.
- R8: After each instruction other than the stop, the instruction pointer advances by 2, wrapping from 0xFE to 0x00.
- R9: Opcode 0001 raises halted in the cycle after its execute cycle. From then until reset, no read or write strobe is raised and halted stays high.
- R10: All sixteen registers, including index 0 and index 15, can be written and read back.
- R11: No-op, stop, constant load and add take 3 cycles. Register load and store take 4 cycles. A store's write strobe falls in the fourth cycle of its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Byte address for the current read or write |
| mem_wdata | output | 8 | Data for a write strobe |
| mem_rdata | input | 8 | Data returned one cycle after a read strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The only writes leaving the core are stores, so a store is what makes register contents visible. Each test program ends its chains of constant loads, adds and loads with a store of the result. A store whose first fetch cycle is cycle S must show its write strobe in cycle S+3, and the bench adds up 3 or 4 cycles per instruction to predict that cycle. The monitor counts cycles from the release of reset and compares the observed cycle as well as the address and data. Halted is due three cycles after the stop instruction's first fetch, and the bench checks that cycle. It also checks that the first fetch address appears during reset and the second one cycle after release.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int unsigned DW     = 8;
  localparam int unsigned NREG   = 16;
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned IW     = 2 * DW;
  localparam int unsigned OPC_W  = 4;

  typedef enum logic [2:0] {
    K_NOP,
    K_HLT,
    K_LDA,
    K_STA,
    K_LDI,
    K_ADD
  } kind_t;

  typedef enum logic [2:0] {
    S_FHI,
    S_FLO,
    S_EXEC,
    S_MEM,
    S_HALT
  } state_t;

  typedef struct packed {
    kind_t             kind;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] sa;
    logic [RIDX_W-1:0] sb;
    logic [DW-1:0]     imm;
  } dec_t;

  // sum of two bytes, carry dropped
  function automatic logic [DW-1:0] add_wrap(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DW-1:0];
  endfunction

  // pointer step that wraps at the byte boundary
  function automatic logic [DW-1:0] ptr_step(input logic [DW-1:0] p,
                                             input logic [DW-1:0] n);
    return add_wrap(p, n);
  endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          dec
);

  logic [OPC_W-1:0] opc;

  assign opc = word[IW-1 -: OPC_W];

  always_comb begin
    dec.dst = word[11:8];
    dec.sa  = word[7:4];
    dec.sb  = word[3:0];
    dec.imm = word[7:0];
    unique case (opc)
      4'b0001: dec.kind = K_HLT;
      4'b0010: dec.kind = K_LDA;
      4'b0011: dec.kind = K_STA;
      4'b0100: dec.kind = K_LDI;
      4'b0101: dec.kind = K_ADD;
      default: dec.kind = K_NOP;  // 0000 and unused codes (R7)
    endcase
  end

endmodule

// File: rtl/brc_regfile.sv
module brc_regfile #(
  parameter int unsigned W     = 8,
  parameter int unsigned N     = 16,
  parameter int unsigned NRD   = 3,
  localparam int unsigned IDXW = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDXW-1:0]           widx,
  input  logic [W-1:0]              wdata,
  input  logic [NRD-1:0][IDXW-1:0]  ridx,
  output logic [NRD-1:0][W-1:0]     rdata
);

  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = regs_q[ridx[g]];
  end

endmodule

// File: rtl/byte_risc_core.sv
module byte_risc_core
  import brc_pkg::*;
#(
  parameter logic [7:0] RESET_IP = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       halted
);

  localparam logic [DW-1:0] STEP_BYTE = DW'(1);
  localparam logic [DW-1:0] STEP_INSN = DW'(IW / DW);
  localparam int unsigned   NRD       = 3;

  state_t            st_q, st_d;
  logic [DW-1:0]     ip_q, ir_hi_q, ir_lo_q;
  logic [IW-1:0]     cur_word;
  dec_t              dec;
  logic [NRD-1:0][RIDX_W-1:0] rd_idx;
  logic [NRD-1:0][DW-1:0]     rd_val;
  logic [DW-1:0]     rv_dst, rv_a, rv_b;

  // named internal events
  logic fetch_hi, in_exec, in_mem;
  logic exec_lda, exec_sta, exec_halt, exec_wb;
  logic mem_lda, mem_sta, retire;
  logic rf_we;
  logic [DW-1:0] rf_wdata;

  // in execute the low byte is still on the read bus
  assign cur_word = (st_q == S_EXEC) ? {ir_hi_q, mem_rdata} : {ir_hi_q, ir_lo_q};

  brc_decode u_dec (
    .word (cur_word),
    .dec  (dec)
  );

  assign rd_idx = {dec.sb, dec.sa, dec.dst};
  assign rv_dst = rd_val[0];
  assign rv_a   = rd_val[1];
  assign rv_b   = rd_val[2];

  assign fetch_hi  = (st_q == S_FHI);
  assign in_exec   = (st_q == S_EXEC);
  assign in_mem    = (st_q == S_MEM);
  assign exec_lda  = in_exec && (dec.kind == K_LDA);
  assign exec_sta  = in_exec && (dec.kind == K_STA);
  assign exec_halt = in_exec && (dec.kind == K_HLT);
  assign exec_wb   = in_exec && ((dec.kind == K_LDI) || (dec.kind == K_ADD));
  assign mem_lda   = in_mem && (dec.kind == K_LDA);
  assign mem_sta   = in_mem && (dec.kind == K_STA);
  assign retire    = (in_exec && ((dec.kind == K_NOP) || (dec.kind == K_LDI) ||
                                  (dec.kind == K_ADD))) || in_mem;

  assign rf_we = exec_wb || mem_lda;

  always_comb begin
    if (mem_lda)               rf_wdata = mem_rdata;
    else if (dec.kind == K_LDI) rf_wdata = dec.imm;
    else                       rf_wdata = add_wrap(rv_a, rv_b);
  end

  brc_regfile #(
    .W   (DW),
    .N   (NREG),
    .NRD (NRD)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .widx  (dec.dst),
    .wdata (rf_wdata),
    .ridx  (rd_idx),
    .rdata (rd_val)
  );

  // sequencer
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_FHI:  st_d = S_FLO;
      S_FLO:  st_d = S_EXEC;
      S_EXEC: begin
        if (exec_halt)                st_d = S_HALT;
        else if (exec_lda || exec_sta) st_d = S_MEM;
        else                          st_d = S_FHI;
      end
      S_MEM:  st_d = S_FHI;
      S_HALT: st_d = S_HALT;
      default: st_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_FHI;
      ip_q    <= RESET_IP;
      ir_hi_q <= '0;
      ir_lo_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_FLO) ir_hi_q <= mem_rdata;
      if (in_exec)       ir_lo_q <= mem_rdata;
      if (retire)        ip_q    <= ptr_step(ip_q, STEP_INSN);
    end
  end

  // memory port
  assign mem_rd    = fetch_hi || (st_q == S_FLO) || exec_lda;
  assign mem_wr    = mem_sta;
  assign mem_wdata = rv_a;
  assign halted    = (st_q == S_HALT);

  always_comb begin
    if (st_q == S_FLO)  mem_addr = ptr_step(ip_q, STEP_BYTE);
    else if (exec_lda)  mem_addr = rv_a;
    else if (mem_sta)   mem_addr = rv_dst;
    else                mem_addr = ip_q;
  end

endmodule

// File: rtl/brc_checks.sv
module brc_checks #(
  parameter logic [7:0] START = 8'hC0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mem_addr,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       halted,
  input logic [7:0] ip,
  input logic       retire,
  input logic       fetch_hi,
  input logic       exec_lda,
  input logic       exec_sta
);

  a_r1_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_rd && (mem_addr == START) && !halted));

  a_r2_fetch_pair: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hi |=> (mem_rd && (mem_addr == 8'($past(mem_addr) + 8'd1))));

  a_r8_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (ip == 8'($past(ip) + 8'd2)));

  a_r8_ip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(ip));

  a_r5_lda_read: assert property (@(posedge clk) disable iff (!rst_n)
    exec_lda |-> (mem_rd && !mem_wr));

  a_r6_sta_write: assert property (@(posedge clk) disable iff (!rst_n)
    exec_sta |=> (mem_wr && !mem_rd));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

endmodule

bind byte_risc_core brc_checks #(.START(RESET_IP)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .halted   (halted),
  .ip       (ip_q),
  .retire   (retire),
  .fetch_hi (fetch_hi),
  .exec_lda (exec_lda),
  .exec_sta (exec_sta)
);

// File: tb/byte_risc_core_bench.sv
module byte_risc_core_bench;

  localparam int PERIOD   = 10;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_rd, mem_wr, halted;

  logic [7:0] mem [256];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // scoreboard: {cycle[15:0], addr, data}
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          cyc = 0;
  int          halt_cyc = -1;
  int          exp_halt = -1;
  bit          quiet_viol = 1'b0;

  // program builder state
  logic [7:0] pc;
  int         cur;

  always #(PERIOD/2) clk = ~clk;

  byte_risc_core u_byte_risc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .halted    (halted)
  );

  // synchronous byte memory: data one cycle after the read strobe
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc      = 0;
      halt_cyc = -1;
    end else begin
      cyc++;
      if (mem_wr) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mem_addr == e[15:8], {t, " addr"}, mem_addr, e[15:8]);
          check(mem_wdata == e[7:0], {t, " data"}, mem_wdata, e[7:0]);
          check(cyc == int'(e[31:16]), "R11 write cycle", cyc, e[31:16]);
        end
      end
      if (halt_cyc >= 0 && (mem_rd || mem_wr)) quiet_viol = 1'b1;
      if (halted && halt_cyc < 0) halt_cyc = cyc;
    end
  end

  task automatic ins(input logic [7:0] hi, input logic [7:0] lo);
    mem[pc] = hi;
    mem[8'(pc + 8'd1)] = lo;
    pc = 8'(pc + 8'd2);
    cur += ((hi[7:4] == 4'h2) || (hi[7:4] == 4'h3)) ? 4 : 3;
  endtask

  task automatic sta(input logic [3:0] ar, input logic [3:0] dr,
                     input logic [7:0] ea, input logic [7:0] ed, input string tag);
    exp_q.push_back({16'(cur + 3), ea, ed});
    tag_q.push_back(tag);
    ins({4'h3, ar}, {dr, 4'h0});
  endtask

  task automatic hlt();
    exp_halt = cur + 3;
    ins(8'h1F, 8'hFF);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    quiet_viol = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(halted == 1'b0, "R1 halted in reset", halted, 0);
    check(mem_rd && !mem_wr, "R1 strobes in reset", {mem_rd, mem_wr}, 2'b10);
    check(mem_addr == 8'hC0, "R1 first fetch address", mem_addr, 8'hC0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2: second byte of the first instruction
    check(mem_rd && mem_addr == 8'hC1, "R2 second fetch byte", mem_addr, 8'hC1);
  endtask

  task automatic wait_halt_and_check(input string tag);
    while (!halted) @(negedge clk);
    repeat (30) @(negedge clk);
    check(halt_cyc == exp_halt, {tag, " R9 halt cycle"}, halt_cyc, exp_halt);
    check(!quiet_viol, "R9 no strobe after halt", quiet_viol, 0);
    check(halted, "R9 halted held", halted, 1);
    check(exp_q.size() == 0, {tag, " R9 pending writes"}, exp_q.size(), 0);
  endtask

  initial begin
    // phase 1: main instruction mix
    clear_mem();
    mem[8'h20] = 8'h77;
    pc = 8'hC0; cur = 0;
    sta(4'h0, 4'h6, 8'h00, 8'h00, "R1 regs zero");
    ins(8'h41, 8'h05);                       // R1 = 05
    ins(8'h42, 8'hFE);                       // R2 = FE
    ins(8'h53, 8'h12);                       // R3 = R1 + R2 = 03
    ins(8'h44, 8'h10);                       // R4 = 10
    sta(4'h4, 4'h3, 8'h10, 8'h03, "R4 add wrap");
    ins(8'h45, 8'h80);                       // R5 = 80
    sta(4'h5, 4'h1, 8'h80, 8'h05, "R3 ldi");
    ins(8'h47, 8'h20);                       // R7 = 20
    ins(8'h28, 8'h70);                       // R8 = mem[R7]
    sta(4'h4, 4'h8, 8'h10, 8'h77, "R5 lda");
    ins(8'h6F, 8'hFF);                       // unused opcode
    ins(8'hF3, 8'h00);                       // unused opcode
    ins(8'h73, 8'h12);                       // unused opcode, add-shaped
    ins(8'h0F, 8'hFF);                       // nop with nonzero low bits
    sta(4'h4, 4'h3, 8'h10, 8'h03, "R7 unused opcodes");
    ins(8'h4F, 8'hAA);                       // R15 = AA
    ins(8'h5E, 8'hFF);                       // R14 = R15 + R15 = 54
    sta(4'h4, 4'hE, 8'h10, 8'h54, "R4 add same source");
    sta(4'h4, 4'hF, 8'h10, 8'hAA, "R10 reg15");
    ins(8'h40, 8'h11);                       // R0 = 11
    sta(4'h0, 4'h0, 8'h11, 8'h11, "R10 reg0 / R6 store");
    hlt();
    ins(8'h34, 8'h10);                       // must never run
    do_reset();
    wait_halt_and_check("P1");

    // phase 2: pointer wrap from FE to 00 (R8)
    exp_q.delete(); tag_q.delete();
    rst_n = 1'b0;
    clear_mem();
    pc = 8'hC0; cur = 0;
    for (int i = 0; i < 32; i++) ins(8'h00, 8'h00);
    ins(8'h41, 8'h3C);                       // at 00: R1 = 3C
    sta(4'h1, 4'h1, 8'h3C, 8'h3C, "R8 pointer wrap");
    hlt();
    ins(8'h31, 8'h10);
    do_reset();
    wait_halt_and_check("P2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule